// File: doc/BRIEF.md
# Full-Speed USB Receive Bit Clock Recovery

This block takes the receive line state of a full-speed USB port and recovers one line-state sample per bit. The block's clock runs at four times the bit rate, so the 12 Mbps line is seen by a 48 MHz clock. The line state first passes through a two-stage synchronizer. A sample counter then places the sampling point half a bit after each observed transition.

Each packet opens with an alternating K/J pattern. While the block is hunting for the start of a packet, every transition realigns the sampling point. When two K samples arrive in a row, the pattern is complete and the phase is frozen for the rest of the packet. When two strobed samples in a row read SE0, the packet has ended and the block returns to hunting.

A separate saturating counter starts when reset is released. It raises a ready flag after a fixed number of enabled clock cycles, so downstream logic can stay in reset while the sampling logic settles. All state advances only on cycles where the clock enable is high.

Top module: `usb_fs_bit_recover`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `bit_stb_o` and `ready_o` are low and `bit_o` reads J. Line encoding on `line_i` and `bit_o`: SE0 = 2'b00, J = 2'b01, K = 2'b10.
- R2: `ready_o` is low after READY_CYCLES-1 enabled clock cycles following reset release. It is high after exactly READY_CYCLES such cycles, and it stays high until the next reset.
- R3: `bit_stb_o` is a single-cycle pulse. Two pulses are never fewer than OSR clock cycles apart.
- R4: While hunting, each transition seen on the synchronized line restarts the sample counter. The strobed sample is the line state OSR/2 samples after that transition. As a result, the data bits after the sync pattern come out equal to the bits sent, whatever phase the line has against the clock.
- R5: Two consecutive strobed K samples freeze the phase. From then until the end of the packet, strobes are spaced exactly OSR cycles apart, even when a one-sample glitch appears on the line in the second sample of a bit.
- R6: Two consecutive strobed SE0 samples return the block to hunting. A following packet with a different phase against the clock is recovered correctly.
- R7: While `ce_i` is low, no state advances and `bit_stb_o` stays low.
- R8: `bit_o` changes only in a cycle where `bit_stb_o` is high.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock, OSR times the bit rate |
| rst_i | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Clock enable; all state holds while low |
| line_i | input | 2 | Asynchronous receive line state (SE0/J/K) |
| bit_o | output | 2 | Recovered line-state sample |
| bit_stb_o | output | 1 | One-cycle pulse marking a new `bit_o` |
| ready_o | output | 1 | Stabilization time since reset release has elapsed |

## Verification
The bench builds the block with its defaults: OSR = 4, READY_CYCLES = 10 and two synchronizer stages. With four samples per bit, the bench can start a packet at each of the four phase offsets against the clock. It can also place a one-sample glitch in the second sample of a bit, away from the midpoint the block should sample. That glitch separates a frozen phase from one that keeps realigning. The ten-cycle ready count is short enough to check both the cycle before the flag rises and the cycle it rises.

// File: rtl/usb_bcr_pkg.sv
package usb_bcr_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    typedef enum logic {
        TRK_HUNT = 1'b0,
        TRK_LOCK = 1'b1
    } trk_t;

endpackage

// File: rtl/usb_bcr_sync.sv
module usb_bcr_sync #(
    parameter int          W       = 2,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         ce_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] feed  [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_feed
            if (g == 0) begin : g_first
                assign feed[g] = d_i;
            end else begin : g_rest
                assign feed[g] = stg_q[g-1];
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            stg_d[i] = ce_i ? feed[i] : stg_q[i];
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst_i) stg_q[i] <= RST_VAL;
            else       stg_q[i] <= stg_d[i];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/usb_bcr_phase.sv
module usb_bcr_phase
    import usb_bcr_pkg::*;
#(
    parameter int OSR = 4
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ce_i,
    input  logic       track_i,
    input  logic [1:0] line_i,
    output logic       stb_o,
    output logic [1:0] smp_o
);
    localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
    localparam int HALF = OSR / 2;

    typedef struct packed {
        logic [1:0]    prev;
        logic [CW-1:0] cnt;
        logic [CW-1:0] gap;
        logic          stb;
        logic [1:0]    smp;
    } ph_t;

    ph_t st_d, st_q;
    logic chg;
    logic fire;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        chg      = 1'b0;
        fire     = 1'b0;
        if (ce_i) begin
            chg       = (line_i != st_q.prev);
            st_d.prev = line_i;
            if (track_i && chg) begin
                st_d.cnt = CW'(1);
            end else if (st_q.cnt == CW'(OSR-1)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            fire = (st_q.cnt == CW'(HALF)) && (st_q.gap == CW'(OSR-1));
            if (fire) begin
                st_d.stb = 1'b1;
                st_d.smp = line_i;
                st_d.gap = '0;
            end else if (st_q.gap != CW'(OSR-1)) begin
                st_d.gap = st_q.gap + CW'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.prev <= LS_J;
            st_q.cnt  <= '0;
            st_q.gap  <= CW'(OSR-1);
            st_q.stb  <= 1'b0;
            st_q.smp  <= LS_J;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o = st_q.stb;
    assign smp_o = st_q.smp;
endmodule

// File: rtl/usb_bcr_framer.sv
module usb_bcr_framer
    import usb_bcr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       stb_i,
    input  logic [1:0] smp_i,
    output logic       track_o
);
    typedef struct packed {
        trk_t st;
        logic last_k;
        logic last_se0;
    } fr_t;

    fr_t fr_d, fr_q;
    logic is_k;
    logic is_se0;

    always_comb begin
        fr_d   = fr_q;
        is_k   = (smp_i == LS_K);
        is_se0 = (smp_i == LS_SE0);
        if (stb_i) begin
            if (fr_q.st == TRK_HUNT && fr_q.last_k && is_k) begin
                fr_d.st = TRK_LOCK;
            end
            if (fr_q.last_se0 && is_se0) begin
                fr_d.st = TRK_HUNT;
            end
            fr_d.last_k   = is_k;
            fr_d.last_se0 = is_se0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fr_q.st       <= TRK_HUNT;
            fr_q.last_k   <= 1'b0;
            fr_q.last_se0 <= 1'b0;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign track_o = (fr_q.st == TRK_HUNT);
endmodule

// File: rtl/usb_bcr_ready.sv
module usb_bcr_ready #(
    parameter int READY_CYCLES = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ce_i,
    output logic ready_o
);
    localparam int RW = $clog2(READY_CYCLES + 1);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          rdy;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (ce_i && rd_q.cnt != RW'(READY_CYCLES)) begin
            rd_d.cnt = rd_q.cnt + RW'(1);
        end
        rd_d.rdy = (rd_d.cnt == RW'(READY_CYCLES));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rd_q.cnt <= '0;
            rd_q.rdy <= 1'b0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign ready_o = rd_q.rdy;
endmodule

// File: rtl/usb_fs_bit_recover.sv
module usb_fs_bit_recover
    import usb_bcr_pkg::*;
#(
    parameter int OSR          = 4,
    parameter int READY_CYCLES = 10,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ce_i,
    input  logic [1:0] line_i,
    output logic [1:0] bit_o,
    output logic       bit_stb_o,
    output logic       ready_o
);
    logic [1:0] line_s;
    logic       track;

    usb_bcr_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LS_J)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ce_i  (ce_i),
        .d_i   (line_i),
        .q_o   (line_s)
    );

    usb_bcr_phase #(
        .OSR (OSR)
    ) u_phase (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ce_i    (ce_i),
        .track_i (track),
        .line_i  (line_s),
        .stb_o   (bit_stb_o),
        .smp_o   (bit_o)
    );

    usb_bcr_framer u_framer (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .stb_i   (bit_stb_o),
        .smp_i   (bit_o),
        .track_o (track)
    );

    usb_bcr_ready #(
        .READY_CYCLES (READY_CYCLES)
    ) u_ready (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ce_i    (ce_i),
        .ready_o (ready_o)
    );
endmodule

// File: rtl/usb_fs_bit_recover_chk.sv
module usb_fs_bit_recover_chk #(
    parameter int OSR = 4
) (
    input logic       clk_i,
    input logic       rst_i,
    input logic       ce_i,
    input logic [1:0] bit_o,
    input logic       bit_stb_o,
    input logic       ready_o
);
    localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;

    logic [CW-1:0] gap_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            gap_q <= CW'(OSR-1);
        end else if (bit_stb_o) begin
            gap_q <= '0;
        end else if (gap_q != CW'(OSR-1)) begin
            gap_q <= gap_q + CW'(1);
        end
    end

    a_r3_strobe_gap: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_stb_o |-> (gap_q == CW'(OSR-1)));

    a_r7_strobe_needs_ce: assert property (@(posedge clk_i) disable iff (rst_i)
        bit_stb_o |-> $past(ce_i));

    a_r8_bit_held: assert property (@(posedge clk_i) disable iff (rst_i)
        !bit_stb_o |-> $stable(bit_o));

    a_r2_ready_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |=> ready_o);

    a_r1_ready_low_at_release: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> !ready_o);
endmodule

bind usb_fs_bit_recover usb_fs_bit_recover_chk #(.OSR(OSR)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ce_i      (ce_i),
    .bit_o     (bit_o),
    .bit_stb_o (bit_stb_o),
    .ready_o   (ready_o)
);

// File: tb/sim_usb_fs_bit_recover.sv
module sim_usb_fs_bit_recover;
    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] J   = 2'b01;
    localparam logic [1:0] K   = 2'b10;
    localparam int NPKT = 6;
    localparam int CAPN = 1024;
    // {phase offset[1:0], data[7:0], glitch}
    localparam logic [10:0] VEC [NPKT] = '{
        {2'd0, 8'hA5, 1'b0},
        {2'd1, 8'h3C, 1'b0},
        {2'd2, 8'hFF, 1'b1},
        {2'd3, 8'h00, 1'b1},
        {2'd2, 8'h96, 1'b0},
        {2'd1, 8'h0F, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce  = 1'b1;
    logic [1:0] line = J;
    logic [1:0] bit_o;
    logic       stb;
    logic       ready;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ncap   = 0;
    int v3     = 0;
    int v8     = 0;
    int last_t = -100;
    logic [1:0] last_bit = J;
    logic       done = 1'b0;
    logic [1:0] cap_v [CAPN];
    int         cap_t [CAPN];

    always #10 clk = ~clk;

    usb_fs_bit_recover u0 (
        .clk_i     (clk),
        .rst_i     (rst),
        .ce_i      (ce),
        .line_i    (line),
        .bit_o     (bit_o),
        .bit_stb_o (stb),
        .ready_o   (ready)
    );

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!stb && bit_o != last_bit) v8++;
            if (stb) begin
                if (cyc - last_t < 4) v3++;
                last_t = cyc;
                if (ncap < CAPN) begin
                    cap_v[ncap] = bit_o;
                    cap_t[ncap] = cyc;
                    ncap++;
                end
            end
        end
        last_bit = bit_o;
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] s, input int n);
        for (int i = 0; i < n; i++) begin
            line = s;
            @(negedge clk);
        end
    endtask

    task automatic packet(input logic [10:0] v);
        logic [1:0] s;
        logic [1:0] exp_v [10];
        int start;
        int pos;
        int bad;
        int badgap;
        start = ncap;
        drive(J, int'(v[10:9]));
        for (int i = 0; i < 8; i++) drive((i == 7 || i % 2 == 0) ? K : J, 4);
        for (int i = 0; i < 8; i++) begin
            s = v[1 + i] ? K : J;
            exp_v[i] = s;
            if (v[0] && i == 3) begin
                drive(s, 1);
                drive((s == J) ? K : J, 1);
                drive(s, 2);
            end else begin
                drive(s, 4);
            end
        end
        exp_v[8] = SE0;
        exp_v[9] = SE0;
        drive(SE0, 8);
        drive(J, 16);
        pos = -1;
        for (int i = start + 1; i < ncap; i++)
            if (pos < 0 && cap_v[i] == K && cap_v[i-1] == K) pos = i;
        bad = 0;
        badgap = 0;
        if (pos < 0 || pos + 10 >= ncap) begin
            bad = 1;
            badgap = 1;
        end else begin
            for (int j = 0; j < 10; j++) begin
                if (cap_v[pos + 1 + j] != exp_v[j]) bad++;
                if (cap_t[pos + 1 + j] - cap_t[pos + j] != 4) badgap++;
            end
        end
        // R4 R6: recovered data and end-of-packet samples match what was sent
        chk($sformatf("R4 R6 packet data %h offset %0d mismatching samples", v[8:1], v[10:9]), bad, 0);
        // R5: frozen phase keeps strobes exactly four cycles apart
        chk($sformatf("R5 packet data %h strobe spacing errors", v[8:1]), badgap, 0);
    endtask

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", int'(stb), 0);
        chk("R1 ready in reset", int'(ready), 0);
        chk("R1 bit in reset", int'(bit_o), int'(J));
        rst = 1'b0;
        repeat (9) @(negedge clk);
        chk("R2 ready after 9 cycles", int'(ready), 0);
        @(negedge clk);
        chk("R2 ready after 10 cycles", int'(ready), 1);
        drive(J, 12);
        for (int p = 0; p < NPKT; p++) packet(VEC[p]);
        ce = 1'b0;
        @(negedge clk);
        n0 = ncap;
        drive(K, 5);
        drive(J, 5);
        chk("R7 strobes while enable low", ncap - n0, 0);
        ce = 1'b1;
        drive(J, 12);
        chk("R3 strobes closer than four cycles", v3, 0);
        chk("R8 bit changes without strobe", v8, 0);
        chk("R2 ready still high at end", int'(ready), 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule